// File: doc/BRIEF.md
# Flash erase command sequencer

This block holds the control and status word that software uses to start a flash erase. It also steps one erase from the request to the end. Software writes a single 32-bit word to pick the memory type and the erase mode and to start the erase. It reads the same word back to follow a four-state lifecycle: idle, pending, in progress and completed. Once completed, the status stays there until software clears it. The configuration fields are frozen whenever the block is not idle. Start requests are dropped while the low-frequency-mode input is high.

Toward the flash array the block uses a request/acknowledge handshake. It raises a request that carries the target sector. The request is accepted in the cycle the array acknowledges it, and the array later returns a one-cycle done pulse. A sector erase covers one sector, chosen by an external sector address. A mass erase walks through every sector not marked write-protected, main sectors first and then information sectors, each in ascending order. A reserved memory-type code or an out-of-range sector address is rejected at once. No array request is issued, and the operation is flagged as an address error.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the read word is 0 and no array request is raised.
- R2: The read word holds type in bits 3:2, mode in bit 1, status in bits 17:16 and the address-error flag in bit 18. All other bits, including start (bit 0) and clear (bit 19), read as 0.
- R3: A write changes type and mode, or starts an erase, only while status is idle (00). In any other state the write leaves them unchanged.
- R4: A sector-mode start (mode 0) with type 00 (main) or 01 (information) and an address below that region's sector count moves status to pending (01) on the next cycle. It raises the request with arr_type 0 for main or 1 for information, and arr_sector set to the address.
- R5: When arr_ack is seen with the request high, status becomes in progress (10) and the request drops on the next cycle. A done pulse while in progress finishes a sector erase with status completed (11) and no address error.
- R6: Completed status holds for any number of cycles. A write with bit 19 set clears bits 18:16 only from completed; in other states, or with bit 19 at 0, the write leaves the status unchanged.
- R7: While lowfreq_i is 1, a start write leaves status idle and raises no request.
- R8: A sector-mode start with a reserved type (10 or 11) or an out-of-range address goes to completed with bit 18 set on the next cycle, and no request is raised.
- R9: A mass erase (mode 1) ignores type and requests each unprotected sector in turn: main sectors 0 upward, then information sectors 0 upward. Status stays 10 between sectors and becomes 11 with no error after the last done pulse. If every sector is protected, it goes straight to 11 with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control and status word |
| lowfreq_i | input | 1 | Low-frequency operating mode, blocks starts |
| sect_addr_i | input | SADDR_W | Sector address for sector erase |
| wp_main_i | input | MAIN_SECTORS | Write-protect bit per main sector |
| wp_info_i | input | INFO_SECTORS | Write-protect bit per information sector |
| arr_req | output | 1 | Erase request to the array controller |
| arr_type | output | 1 | Region of the requested sector: 0 main, 1 information |
| arr_sector | output | SADDR_W | Sector index within the region |
| arr_ack | input | 1 | Array accepts the request |
| arr_done | input | 1 | One-cycle pulse: the current sector is erased |

## Verification
Every result is registered once, so it shows up in the cycle after the edge that sampled its cause. A start, a clear, an acknowledge or a done pulse changes reg_rdata and arr_req one clock after it is seen. Configuration writes appear in the read word after one edge in the same way. The bench drives each input on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It then holds the inputs steady for extra cycles to show that completed and locked values do not move. In a mass erase the next sector's request is due one cycle after each done pulse, and the bench compares it against its own ordered list of unprotected sectors.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } fes_state_e;

  localparam logic [1:0] STAT_IDLE = 2'b00;
  localparam logic [1:0] STAT_PEND = 2'b01;
  localparam logic [1:0] STAT_BUSY = 2'b10;
  localparam logic [1:0] STAT_DONE = 2'b11;

  localparam int BIT_START = 0;
  localparam int BIT_MODE  = 1;
  localparam int BIT_TYPE  = 2;
  localparam int BIT_STAT  = 16;
  localparam int BIT_ERR   = 18;
  localparam int BIT_CLEAR = 19;

  // Status code reported for each internal state.
  function automatic logic [1:0] status_of(fes_state_e s);
    case (s)
      ST_IDLE: status_of = STAT_IDLE;
      ST_PEND: status_of = STAT_PEND;
      ST_REQ,
      ST_WAIT: status_of = STAT_BUSY;
      default: status_of = STAT_DONE;
    endcase
  endfunction

  // Type codes with the high bit set are reserved.
  function automatic logic type_reserved(logic [1:0] t);
    type_reserved = t[1];
  endfunction

  // A sector-mode target is valid when the type is real and the address
  // lies inside the selected region.
  function automatic logic sector_ok(logic [31:0] addr, logic [1:0] t,
                                     int main_n, int info_n);
    int limit;
    limit = t[0] ? info_n : main_n;
    sector_ok = !type_reserved(t) && (addr < 32'(limit));
  endfunction

  // Flat index over main sectors followed by information sectors.
  function automatic logic [31:0] flat_index(logic [31:0] addr, logic [1:0] t,
                                             int main_n);
    flat_index = t[0] ? addr + 32'(main_n) : addr;
  endfunction

  // Region bit of a flat index.
  function automatic logic in_info(logic [31:0] idx, int main_n);
    in_info = idx >= 32'(main_n);
  endfunction

  // Sector number within its region.
  function automatic logic [31:0] local_index(logic [31:0] idx, int main_n);
    local_index = in_info(idx, main_n) ? idx - 32'(main_n) : idx;
  endfunction

endpackage

// File: rtl/fes_regfile.sv
module fes_regfile
  import fes_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  status,
  input  logic        lowfreq_i,
  output logic [1:0]  type_q,
  output logic        mode_q,
  output logic [1:0]  cmd_type,
  output logic        cmd_mode,
  output logic        cfg_write,
  output logic        start_accept,
  output logic        clear_accept
);

  logic is_idle;
  logic unused_wbits;

  assign is_idle      = (status == STAT_IDLE);
  assign cmd_type     = reg_wdata[BIT_TYPE +: 2];
  assign cmd_mode     = reg_wdata[BIT_MODE];
  assign cfg_write    = reg_wr && is_idle;
  assign start_accept = cfg_write && reg_wdata[BIT_START] && !lowfreq_i;
  assign clear_accept = reg_wr && reg_wdata[BIT_CLEAR] && (status == STAT_DONE);
  assign unused_wbits = ^{reg_wdata[31:20], reg_wdata[18:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q <= 2'b00;
      mode_q <= 1'b0;
    end else if (cfg_write) begin
      type_q <= cmd_type;
      mode_q <= cmd_mode;
    end
  end

endmodule

// File: rtl/fes_scan.sv
module fes_scan #(
  parameter int N     = 10,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]   wp,
  input  logic [IDX_W:0] from,
  output logic           found,
  output logic [IDX_W-1:0] idx
);

  logic [N-1:0] cand;

  for (genvar g = 0; g < N; g++) begin : g_cand
    localparam logic [IDX_W:0] GI = (IDX_W+1)'(g);
    assign cand[g] = !wp[g] && (from <= GI);
  end

  // Lowest candidate wins: scan from the top so lower indices overwrite.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/fes_fsm.sv
module fes_fsm
  import fes_pkg::*;
#(
  parameter int MAIN_SECTORS = 8,
  parameter int INFO_SECTORS = 2,
  parameter int SADDR_W      = 4,
  parameter int IDX_W        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_accept,
  input  logic               clear_accept,
  input  logic [1:0]         cmd_type,
  input  logic               cmd_mode,
  input  logic [SADDR_W-1:0] sect_addr_i,
  input  logic               arr_ack,
  input  logic               arr_done,
  input  logic               scan_found,
  input  logic [IDX_W-1:0]   scan_idx,
  output fes_state_e         state,
  output logic               addr_err,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [IDX_W:0]     scan_from,
  output logic               req_accept,
  output logic               sector_done
);

  logic mass_q;
  logic target_ok;
  logic [IDX_W-1:0] target_idx;

  assign target_ok   = sector_ok(32'(sect_addr_i), cmd_type, MAIN_SECTORS, INFO_SECTORS);
  assign target_idx  = IDX_W'(flat_index(32'(sect_addr_i), cmd_type, MAIN_SECTORS));
  assign req_accept  = arr_ack && (state == ST_PEND || state == ST_REQ);
  assign sector_done = arr_done && (state == ST_WAIT);
  assign scan_from   = (state == ST_IDLE) ? '0 : ({1'b0, cur_idx} + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_err <= 1'b0;
      cur_idx  <= '0;
      mass_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_accept) begin
            mass_q <= cmd_mode;
            if (cmd_mode) begin
              if (scan_found) begin
                cur_idx <= scan_idx;
                state   <= ST_PEND;
              end else begin
                state   <= ST_DONE;
              end
            end else if (!target_ok) begin
              addr_err <= 1'b1;
              state    <= ST_DONE;
            end else begin
              cur_idx <= target_idx;
              state   <= ST_PEND;
            end
          end
        end
        ST_PEND,
        ST_REQ: begin
          if (req_accept) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (sector_done) begin
            if (mass_q && scan_found) begin
              cur_idx <= scan_idx;
              state   <= ST_REQ;
            end else begin
              state   <= ST_DONE;
            end
          end
        end
        default: begin
          if (clear_accept) begin
            addr_err <= 1'b0;
            state    <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int MAIN_SECTORS = 8,
  parameter int INFO_SECTORS = 2,
  parameter int SADDR_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    lowfreq_i,
  input  logic [SADDR_W-1:0]      sect_addr_i,
  input  logic [MAIN_SECTORS-1:0] wp_main_i,
  input  logic [INFO_SECTORS-1:0] wp_info_i,
  output logic                    arr_req,
  output logic                    arr_type,
  output logic [SADDR_W-1:0]      arr_sector,
  input  logic                    arr_ack,
  input  logic                    arr_done
);

  localparam int TOTAL = MAIN_SECTORS + INFO_SECTORS;
  localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  fes_state_e       state;
  logic [1:0]       status;
  logic [1:0]       type_q;
  logic             mode_q;
  logic [1:0]       cmd_type;
  logic             cmd_mode;
  logic             cfg_write;
  logic             start_accept;
  logic             clear_accept;
  logic             req_accept;
  logic             sector_done;
  logic             addr_err;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W:0]   scan_from;
  logic             scan_found;
  logic [IDX_W-1:0] scan_idx;
  logic [TOTAL-1:0] wp_all;

  assign status = status_of(state);
  assign wp_all = {wp_info_i, wp_main_i};

  fes_regfile i_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .status       (status),
    .lowfreq_i    (lowfreq_i),
    .type_q       (type_q),
    .mode_q       (mode_q),
    .cmd_type     (cmd_type),
    .cmd_mode     (cmd_mode),
    .cfg_write    (cfg_write),
    .start_accept (start_accept),
    .clear_accept (clear_accept)
  );

  fes_scan #(.N(TOTAL), .IDX_W(IDX_W)) i_scan (
    .wp    (wp_all),
    .from  (scan_from),
    .found (scan_found),
    .idx   (scan_idx)
  );

  fes_fsm #(
    .MAIN_SECTORS (MAIN_SECTORS),
    .INFO_SECTORS (INFO_SECTORS),
    .SADDR_W      (SADDR_W),
    .IDX_W        (IDX_W)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_accept (start_accept),
    .clear_accept (clear_accept),
    .cmd_type     (cmd_type),
    .cmd_mode     (cmd_mode),
    .sect_addr_i  (sect_addr_i),
    .arr_ack      (arr_ack),
    .arr_done     (arr_done),
    .scan_found   (scan_found),
    .scan_idx     (scan_idx),
    .state        (state),
    .addr_err     (addr_err),
    .cur_idx      (cur_idx),
    .scan_from    (scan_from),
    .req_accept   (req_accept),
    .sector_done  (sector_done)
  );

  assign arr_req    = (state == ST_PEND) || (state == ST_REQ);
  assign arr_type   = in_info(32'(cur_idx), MAIN_SECTORS);
  assign arr_sector = SADDR_W'(local_index(32'(cur_idx), MAIN_SECTORS));

  always_comb begin
    reg_rdata                 = '0;
    reg_rdata[BIT_TYPE +: 2]  = type_q;
    reg_rdata[BIT_MODE]       = mode_q;
    reg_rdata[BIT_STAT +: 2]  = status;
    reg_rdata[BIT_ERR]        = addr_err;
  end

endmodule

// File: rtl/fes_checker.sv
module fes_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        lowfreq_i,
  input logic        arr_req,
  input logic        req_accept,
  input logic        clear_accept,
  input logic [31:0] reg_rdata
);

  logic [1:0] st;
  assign st = reg_rdata[17:16];

  a_r4_req_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> (st == 2'b01 || st == 2'b10));

  a_r8_err_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[18] |-> (st == 2'b11));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b11 && !clear_accept) |=> (st == 2'b11));

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'b00) |=> $stable(reg_rdata[3:1]));

  a_r7_lowfreq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lowfreq_i && st == 2'b00) |=> (st == 2'b00));

  a_r5_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> (st == 2'b10 && !arr_req));

  a_r2_wo_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[19] == 1'b0 && reg_rdata[0] == 1'b0));

endmodule

bind flash_erase_seq fes_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lowfreq_i    (lowfreq_i),
  .arr_req      (arr_req),
  .req_accept   (req_accept),
  .clear_accept (clear_accept),
  .reg_rdata    (reg_rdata)
);

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/1ps
module test_flash_erase_seq;

  localparam int MAIN = 8;
  localparam int INFO = 2;
  localparam int SW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            lowfreq_i = 1'b0;
  logic [SW-1:0]   sect_addr_i = '0;
  logic [MAIN-1:0] wp_main_i = '0;
  logic [INFO-1:0] wp_info_i = '0;
  logic            arr_req;
  logic            arr_type;
  logic [SW-1:0]   arr_sector;
  logic            arr_ack = 1'b0;
  logic            arr_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_erase_seq #(.MAIN_SECTORS(MAIN), .INFO_SECTORS(INFO), .SADDR_W(SW)) i_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lowfreq_i(lowfreq_i), .sect_addr_i(sect_addr_i),
    .wp_main_i(wp_main_i), .wp_info_i(wp_info_i), .arr_req(arr_req),
    .arr_type(arr_type), .arr_sector(arr_sector), .arr_ack(arr_ack),
    .arr_done(arr_done)
  );

  function automatic logic [31:0] word(logic [1:0] st, logic err, logic [1:0] ty, logic md);
    return (32'(err) << 18) | (32'(st) << 16) | (32'(ty) << 2) | (32'(md) << 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(negedge clk); arr_ack = 1'b1;
    @(negedge clk); arr_ack = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); arr_done = 1'b1;
    @(negedge clk); arr_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 read word after reset", reg_rdata, 32'h0);
    chk("R1 request after reset", 32'(arr_req), 32'h0);
  endtask

  task automatic t_config();
    wr(32'h0000_0004);
    chk("R2 type field in bits 3:2", reg_rdata, word(2'b00, 1'b0, 2'b01, 1'b0));
    wr(32'hFFF7_FFFE);
    chk("R2 reserved bits read zero", reg_rdata, word(2'b00, 1'b0, 2'b11, 1'b1));
    wr(32'h0008_0000);
    chk("R6 clear in idle has no effect", reg_rdata, word(2'b00, 1'b0, 2'b00, 1'b0));
  endtask

  task automatic t_sector();
    sect_addr_i = 4'd5;
    wr(32'h0000_0001);
    chk("R4 status pending", reg_rdata, word(2'b01, 1'b0, 2'b00, 1'b0));
    chk("R4 request raised", 32'(arr_req), 32'h1);
    chk("R4 request region main", 32'(arr_type), 32'h0);
    chk("R4 request sector", 32'(arr_sector), 32'd5);
    wr(32'h0000_000F);
    chk("R3 config locked while pending", reg_rdata, word(2'b01, 1'b0, 2'b00, 1'b0));
    ack_pulse();
    chk("R5 busy after ack", reg_rdata, word(2'b10, 1'b0, 2'b00, 1'b0));
    chk("R5 request dropped after ack", 32'(arr_req), 32'h0);
    wr(32'h0008_0000);
    chk("R6 clear while busy ignored", reg_rdata, word(2'b10, 1'b0, 2'b00, 1'b0));
    idle(3);
    done_pulse();
    chk("R5 completed after done", reg_rdata, word(2'b11, 1'b0, 2'b00, 1'b0));
    idle(6);
    chk("R6 completed persists", reg_rdata, word(2'b11, 1'b0, 2'b00, 1'b0));
    wr(32'h0000_000F);
    chk("R6 write without clear bit", reg_rdata, word(2'b11, 1'b0, 2'b00, 1'b0));
    wr(32'h0008_0000);
    chk("R6 clear from completed", reg_rdata, word(2'b00, 1'b0, 2'b00, 1'b0));
    sect_addr_i = 4'd1;
    wr(32'h0000_0005);
    chk("R4 info status pending", reg_rdata, word(2'b01, 1'b0, 2'b01, 1'b0));
    chk("R4 info region", 32'(arr_type), 32'h1);
    chk("R4 info sector", 32'(arr_sector), 32'd1);
    ack_pulse();
    done_pulse();
    chk("R5 info completed", reg_rdata, word(2'b11, 1'b0, 2'b01, 1'b0));
    wr(32'h0008_0000);
  endtask

  task automatic t_lowfreq();
    lowfreq_i = 1'b1;
    sect_addr_i = 4'd2;
    wr(32'h0000_0001);
    chk("R7 start blocked in low-frequency mode", 32'(reg_rdata[17:16]), 32'h0);
    chk("R7 no request in low-frequency mode", 32'(arr_req), 32'h0);
    lowfreq_i = 1'b0;
  endtask

  task automatic t_reserved();
    sect_addr_i = 4'd0;
    wr(32'h0000_0009);
    chk("R8 reserved type error", reg_rdata, word(2'b11, 1'b1, 2'b10, 1'b0));
    chk("R8 reserved type no request", 32'(arr_req), 32'h0);
    wr(32'h0008_0000);
    chk("R6 clear keeps type", reg_rdata, word(2'b00, 1'b0, 2'b10, 1'b0));
    sect_addr_i = 4'd9;
    wr(32'h0000_0001);
    chk("R8 main address out of range", reg_rdata, word(2'b11, 1'b1, 2'b00, 1'b0));
    wr(32'h0008_0000);
    sect_addr_i = 4'd2;
    wr(32'h0000_0005);
    chk("R8 info address out of range", reg_rdata, word(2'b11, 1'b1, 2'b01, 1'b0));
    chk("R8 info out of range no request", 32'(arr_req), 32'h0);
    wr(32'h0008_0000);
  endtask

  task automatic t_mass();
    int exp_list[$];
    wp_main_i = 8'b0010_0110;
    wp_info_i = 2'b01;
    for (int i = 0; i < MAIN; i++) if (!wp_main_i[i]) exp_list.push_back(i);
    for (int i = 0; i < INFO; i++) if (!wp_info_i[i]) exp_list.push_back(MAIN + i);
    wr(32'h0000_000B);
    chk("R9 mass first status pending", reg_rdata, word(2'b01, 1'b0, 2'b10, 1'b1));
    foreach (exp_list[k]) begin
      chk("R9 mass request raised", 32'(arr_req), 32'h1);
      chk("R9 mass region", 32'(arr_type), 32'(exp_list[k] >= MAIN));
      chk("R9 mass sector", 32'(arr_sector),
          32'(exp_list[k] >= MAIN ? exp_list[k] - MAIN : exp_list[k]));
      ack_pulse();
      chk("R9 mass busy", reg_rdata, word(2'b10, 1'b0, 2'b10, 1'b1));
      done_pulse();
      if (k != exp_list.size() - 1)
        chk("R9 mass still busy between sectors", 32'(reg_rdata[17:16]), 32'h2);
    end
    chk("R9 mass completed", reg_rdata, word(2'b11, 1'b0, 2'b10, 1'b1));
    chk("R9 mass no further request", 32'(arr_req), 32'h0);
    wr(32'h0008_0000);
    wp_main_i = '1;
    wp_info_i = '1;
    wr(32'h0000_0003);
    chk("R9 all protected completes at once", reg_rdata, word(2'b11, 1'b0, 2'b00, 1'b1));
    chk("R9 all protected no request", 32'(arr_req), 32'h0);
    wr(32'h0008_0000);
    wp_main_i = '0;
    wp_info_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_sector();
    t_lowfreq();
    t_reserved();
    t_mass();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule